// File: doc/BRIEF.md
# Flash Program/Erase Key Guard

This block sits in front of a nonvolatile memory controller and decides whether program and erase operations may run. Software writes bytes to a key register. The block checks these bytes against a fixed key protocol. A two-byte unlock sequence opens the controller in one of two ways: for exactly one operation, or for any number of operations until an explicit relock sequence closes it again. The gap between key writes does not matter; only their order does.

Each program or erase request arrives as a one-cycle pulse. If the block is open, the request is passed on as a one-cycle grant in the same cycle. The controller reports each completed operation with a done pulse.

Any violation trips a sticky lockout that only reset can clear. Violations are a wrong key byte, correct bytes in the wrong order, or a request made while the block is closed. While the lockout holds, no operation can be granted.

Top module: `flash_key_guard`

## Requirements
- R1: After reset, `op_enable`, `multi_mode`, `lockout` and `op_grant` are all low, and the block is in the closed state.
- R2: In the closed state, writing the arm byte 0xA5 and then the single byte 0xF1 raises `op_enable` on the cycle after the second write, with `multi_mode` low. Any number of idle cycles may separate the two writes.
- R3: Writing 0xA5 and then the multi byte 0xF2 raises both `op_enable` and `multi_mode` on the cycle after the second write.
- R4: `op_grant` is high in exactly the cycles where `op_req` is high, `key_wr` is low, and the block is open with no single-shot operation already in flight. A request in any other cycle produces no grant.
- R5: In single mode, after one grant `op_enable` stays high until `op_done`, then drops on the next cycle. A further operation needs the full key sequence again.
- R6: In multi mode, `op_enable` and `multi_mode` stay high across any number of granted requests and done pulses.
- R7: In multi mode, writing 0xA5 and then the relock byte 0x5A closes the block on the cycle after the second write, with `lockout` low. A new unlock sequence is then accepted. Requests between the two relock bytes are still granted.
- R8: Any of the following raises `lockout` on the next cycle:
  - a first byte other than 0xA5 in the closed state;
  - a second byte other than 0xF1 or 0xF2 after the arm byte;
  - a second byte other than 0x5A after the arm byte in multi mode;
  - any key write while single mode is open.
- R9: A request while closed, including after only the arm byte, gives no grant and raises `lockout` on the next cycle.
- R10: While `lockout` is high, `op_enable` and `multi_mode` are low. Key writes, requests and done pulses have no effect, and no grant is given. Only reset clears it.
- R11: A cycle with `key_wr` and `op_req` both high gives no grant and raises `lockout` on the next cycle.
- R12: In single mode, a second request after the grant and before `op_done` gives no grant and raises `lockout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr | input | 1 | Key register write strobe |
| key_data | input | 8 | Key byte written with `key_wr` |
| op_req | input | 1 | Program/erase request pulse |
| op_done | input | 1 | Program/erase completion pulse |
| op_grant | output | 1 | Request passed through to the controller |
| op_enable | output | 1 | Block open for program/erase |
| multi_mode | output | 1 | Open in multi-operation mode |
| lockout | output | 1 | Sticky violation lockout |

## Verification
The bench builds the block with its default key width of 8 and the default four key byte values. A weighted random draw produces the arm, single, multi and relock bytes far more often than other values, so both open modes and the relock path are reached often, not just the lockout. Frequent resets during the random phase let the run pass through many separate unlock, operate and relock sessions, rather than ending in one lockout.

// File: rtl/flash_key_pkg.sv
package flash_key_pkg;
  typedef enum logic [2:0] {
    GS_CLOSED  = 3'd0,
    GS_ARMED   = 3'd1,
    GS_ONE     = 3'd2,
    GS_ONE_BSY = 3'd3,
    GS_MULTI   = 3'd4,
    GS_M_ARMED = 3'd5,
    GS_LOCKOUT = 3'd6
  } guard_state_t;

  typedef enum logic [2:0] {
    KC_ARM    = 3'd0,
    KC_ONE    = 3'd1,
    KC_MULTI  = 3'd2,
    KC_RELOCK = 3'd3,
    KC_BAD    = 3'd4
  } key_class_t;

  function automatic logic is_open(input guard_state_t s);
    return (s == GS_ONE) || (s == GS_ONE_BSY) || (s == GS_MULTI) || (s == GS_M_ARMED);
  endfunction

  function automatic logic can_grant(input guard_state_t s);
    return (s == GS_ONE) || (s == GS_MULTI) || (s == GS_M_ARMED);
  endfunction
endpackage

// File: rtl/key_classifier.sv
module key_classifier #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] ARM_VAL    = 8'hA5,
  parameter logic [KEY_W-1:0] ONE_VAL    = 8'hF1,
  parameter logic [KEY_W-1:0] MULTI_VAL  = 8'hF2,
  parameter logic [KEY_W-1:0] RELOCK_VAL = 8'h5A
) (
  input  logic [KEY_W-1:0]         key_byte,
  output flash_key_pkg::key_class_t key_cls
);
  import flash_key_pkg::*;

  function automatic key_class_t classify(input logic [KEY_W-1:0] b);
    if (b == ARM_VAL)         return KC_ARM;
    else if (b == ONE_VAL)    return KC_ONE;
    else if (b == MULTI_VAL)  return KC_MULTI;
    else if (b == RELOCK_VAL) return KC_RELOCK;
    else                      return KC_BAD;
  endfunction

  assign key_cls = classify(key_byte);
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_wr,
  input  flash_key_pkg::key_class_t key_cls,
  input  logic                      op_req,
  input  logic                      op_done,
  output logic                      op_grant,
  output logic                      op_enable,
  output logic                      multi_mode,
  output logic                      lockout
);
  import flash_key_pkg::*;

  guard_state_t state_q, state_d;
  logic         violation;

  always_comb begin
    state_d   = state_q;
    violation = 1'b0;
    if (state_q != GS_LOCKOUT) begin
      if (key_wr && op_req) begin
        violation = 1'b1;
      end else if (op_req) begin
        case (state_q)
          GS_ONE:               state_d = GS_ONE_BSY;
          GS_MULTI, GS_M_ARMED: state_d = state_q;
          default:              violation = 1'b1;
        endcase
      end else if (key_wr) begin
        case (state_q)
          GS_CLOSED: if (key_cls == KC_ARM) state_d = GS_ARMED; else violation = 1'b1;
          GS_ARMED: begin
            if (key_cls == KC_ONE)        state_d = GS_ONE;
            else if (key_cls == KC_MULTI) state_d = GS_MULTI;
            else                          violation = 1'b1;
          end
          GS_MULTI:   if (key_cls == KC_ARM)    state_d = GS_M_ARMED; else violation = 1'b1;
          GS_M_ARMED: if (key_cls == KC_RELOCK) state_d = GS_CLOSED;  else violation = 1'b1;
          default:    violation = 1'b1;
        endcase
      end else if (op_done && state_q == GS_ONE_BSY) begin
        state_d = GS_CLOSED;
      end
      if (violation) state_d = GS_LOCKOUT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= GS_CLOSED;
    else        state_q <= state_d;
  end

  assign op_grant   = op_req && !key_wr && can_grant(state_q);
  assign op_enable  = is_open(state_q);
  assign multi_mode = (state_q == GS_MULTI) || (state_q == GS_M_ARMED);
  assign lockout    = (state_q == GS_LOCKOUT);

  // R10: lockout holds until reset
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> lockout);
  // R10: nothing open while locked out
  a_r10_lock_closed: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (!op_enable && !multi_mode && !op_grant));
  // R4: grant only while open
  a_r4_grant_open: assert property (@(posedge clk) disable iff (!rst_n)
    op_grant |-> (op_enable && op_req && !key_wr));
  // R9: request while closed trips lockout
  a_r9_req_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_enable) |=> lockout);
  // R11: simultaneous key write and request trips lockout
  a_r11_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && key_wr) |=> lockout);
  // R6: multi mode implies open
  a_r6_multi_open: assert property (@(posedge clk) disable iff (!rst_n)
    multi_mode |-> op_enable);
  // R5: a granted single-shot op keeps the block open and not multi
  a_r5_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_grant && !multi_mode) |=> (op_enable || lockout));
endmodule

// File: rtl/flash_key_guard.sv
module flash_key_guard #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] ARM_VAL    = 8'hA5,
  parameter logic [KEY_W-1:0] ONE_VAL    = 8'hF1,
  parameter logic [KEY_W-1:0] MULTI_VAL  = 8'hF2,
  parameter logic [KEY_W-1:0] RELOCK_VAL = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             op_req,
  input  logic             op_done,
  output logic             op_grant,
  output logic             op_enable,
  output logic             multi_mode,
  output logic             lockout
);
  import flash_key_pkg::*;

  key_class_t key_cls;

  key_classifier #(
    .KEY_W(KEY_W), .ARM_VAL(ARM_VAL), .ONE_VAL(ONE_VAL),
    .MULTI_VAL(MULTI_VAL), .RELOCK_VAL(RELOCK_VAL)
  ) u_cls (
    .key_byte(key_data),
    .key_cls (key_cls)
  );

  guard_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .key_cls   (key_cls),
    .op_req    (op_req),
    .op_done   (op_done),
    .op_grant  (op_grant),
    .op_enable (op_enable),
    .multi_mode(multi_mode),
    .lockout   (lockout)
  );
endmodule

// File: tb/flash_key_guard_tb.sv
module flash_key_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       op_req = 1'b0;
  logic       op_done = 1'b0;
  logic       op_grant, op_enable, multi_mode, lockout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state: 0 closed,1 armed,2 one,3 one busy,4 multi,5 multi armed,6 lockout
  int m_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_key_guard u_dut (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
    .op_req(op_req), .op_done(op_done), .op_grant(op_grant),
    .op_enable(op_enable), .multi_mode(multi_mode), .lockout(lockout)
  );

  function automatic bit exp_open(int s);
    return s == 2 || s == 3 || s == 4 || s == 5;
  endfunction

  function automatic bit exp_grant(int s, bit kw, bit rq);
    return rq && !kw && (s == 2 || s == 4 || s == 5);
  endfunction

  function automatic int step(int s, bit kw, logic [7:0] kd, bit rq, bit dn);
    if (s == 6) return 6;
    if (kw && rq) return 6;
    if (rq) return (s == 2) ? 3 : (s == 4 || s == 5) ? s : 6;
    if (kw) begin
      if (s == 0) return (kd == 8'hA5) ? 1 : 6;
      if (s == 1) return (kd == 8'hF1) ? 2 : (kd == 8'hF2) ? 4 : 6;
      if (s == 4) return (kd == 8'hA5) ? 5 : 6;
      if (s == 5) return (kd == 8'h5A) ? 0 : 6;
      return 6;
    end
    if (dn && s == 3) return 0;
    return s;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // drive one cycle at negedge, check outputs against model, advance model
  task automatic cyc(string tag, bit kw, logic [7:0] kd, bit rq, bit dn);
    @(negedge clk);
    key_wr = kw; key_data = kd; op_req = rq; op_done = dn;
    #1;
    chk(tag, "op_grant",   op_grant,   exp_grant(m_st, kw, rq));
    chk(tag, "op_enable",  op_enable,  exp_open(m_st));
    chk(tag, "multi_mode", multi_mode, (m_st == 4 || m_st == 5));
    chk(tag, "lockout",    lockout,    (m_st == 6));
    m_st = step(m_st, kw, kd, rq, dn);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 8'h00, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; key_wr = 0; op_req = 0; op_done = 0;
    @(negedge clk);
    rst_n = 1;
    m_st = 0;
  endtask

  task automatic expect_state(string tag, int s);
    checks++;
    if (m_st != s) begin
      errors++;
      $display("FAIL %s model state actual=%0d expected=%0d", tag, m_st, s);
    end
  endtask

  initial begin
    do_reset();
    idle("R1", 2);

    // R2 single unlock with gap
    cyc("R2", 1, 8'hA5, 0, 0); idle("R2", 7); cyc("R2", 1, 8'hF1, 0, 0);
    idle("R2", 1);
    chk("R2", "op_enable after F1", op_enable, 1'b1);
    // R5 one op then closed
    cyc("R5", 0, 0, 1, 0); idle("R5", 3); cyc("R5", 0, 0, 0, 1); idle("R5", 1);
    chk("R5", "closed after done", op_enable, 1'b0);
    // R9 request while closed
    cyc("R9", 0, 0, 1, 0); idle("R9", 2);
    chk("R9", "lockout after closed req", lockout, 1'b1);
    // R10 ignores keys and requests
    cyc("R10", 1, 8'hA5, 0, 0); cyc("R10", 1, 8'hF2, 0, 0); cyc("R10", 0, 0, 1, 0);
    idle("R10", 1);
    chk("R10", "still locked out", lockout, 1'b1);

    // R3 and R6 multi mode
    do_reset();
    cyc("R3", 1, 8'hA5, 0, 0); cyc("R3", 1, 8'hF2, 0, 0); idle("R3", 1);
    chk("R3", "multi_mode", multi_mode, 1'b1);
    for (int i = 0; i < 5; i++) begin
      cyc("R6", 0, 0, 1, 0); cyc("R6", 0, 0, 0, 1);
    end
    // R7 relock with request between bytes
    cyc("R7", 1, 8'hA5, 0, 0); cyc("R7", 0, 0, 1, 0); cyc("R7", 1, 8'h5A, 0, 0);
    idle("R7", 1);
    chk("R7", "closed after relock", op_enable, 1'b0);
    chk("R7", "no lockout after relock", lockout, 1'b0);
    cyc("R7", 1, 8'hA5, 0, 0); cyc("R7", 1, 8'hF1, 0, 0); idle("R7", 1);
    chk("R7", "reopen after relock", op_enable, 1'b1);
    // R8 key write while single open
    cyc("R8", 1, 8'hA5, 0, 0); idle("R8", 1);
    chk("R8", "key in single mode", lockout, 1'b1);

    // R8 bad first byte / bad second byte
    do_reset(); cyc("R8", 1, 8'hF1, 0, 0); idle("R8", 1); expect_state("R8", 6);
    do_reset(); cyc("R8", 1, 8'hA5, 0, 0); cyc("R8", 1, 8'h5A, 0, 0); idle("R8", 1);
    do_reset(); cyc("R8", 1, 8'hA5, 0, 0); cyc("R8", 1, 8'hF2, 0, 0);
    cyc("R8", 1, 8'hA5, 0, 0); cyc("R8", 1, 8'hF1, 0, 0); idle("R8", 1);
    // R9 request after arm only
    do_reset(); cyc("R9", 1, 8'hA5, 0, 0); cyc("R9", 0, 0, 1, 0); idle("R9", 1);
    // R11 collision
    do_reset(); cyc("R11", 1, 8'hA5, 0, 0); cyc("R11", 1, 8'hF2, 0, 0);
    cyc("R11", 1, 8'hA5, 1, 0); idle("R11", 1); expect_state("R11", 6);
    // R12 second request in flight
    do_reset(); cyc("R12", 1, 8'hA5, 0, 0); cyc("R12", 1, 8'hF1, 0, 0);
    cyc("R12", 0, 0, 1, 0); cyc("R12", 0, 0, 1, 0); idle("R12", 1);
    expect_state("R12", 6);
    // R1 reset clears lockout
    do_reset(); idle("R1", 1);

    // random phase (R4 grant rule across all states)
    void'($urandom(32'd7741));
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] kd;
      int pick = $urandom_range(0, 9);
      kd = (pick < 3) ? 8'hA5 : (pick < 5) ? 8'hF2 : (pick < 7) ? 8'hF1 :
           (pick < 9) ? 8'h5A : 8'($urandom);
      if (r < 4) do_reset();
      else if (r < 30) cyc("R4", 1, kd, 0, 0);
      else if (r < 50) cyc("R4", 0, 0, 1, 0);
      else if (r < 65) cyc("R4", 0, 0, 0, 1);
      else if (r < 67) cyc("R4", 1, kd, 1, 0);
      else cyc("R4", 0, 0, 0, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule